// File: doc/BRIEF.md
# Transmit Queue DMA Request Generator

This block sits on the write side of one virtual channel's transmit queue. A system DMA engine fills the queue with 32-bit payload words over a burst write port. A downstream packet engine drains it through a simple pop port. The block compares the free space in the queue with a software-chosen transfer size. It raises a DMA request whenever one full transfer of that size would fit.

Software also programs the payload length in bytes, taken from the packet header. Every accepted beat adds four bytes to a running total. Once the total reaches the programmed length, the request is withdrawn, even if the last chunk was shorter than a full transfer. Loading a new length, or enabling the block, clears the total and arms the request again. A 3-bit selector picks which of several request lines carries the request. A configuration error is flagged when the queue size is not an exact multiple of the transfer size.

Top module: `txq_dma_req`

## Requirements
- R1: The 3-bit threshold code k selects a transfer size of 2^k words (code 0 = 1 word, code 7 = 128 words).
- R2: The request is high only when cfg_en is 1, cfg_err is 0, the payload is not complete, and the free entries (DEPTH minus stored words) are at least the transfer size.
- R3: Once the byte total reaches cfg_wc, the request drops even when free space still allows a transfer, including when cfg_wc is not a multiple of the transfer size in bytes.
- R4: While the queue is not full, wr_ready is high, so a burst is accepted on consecutive cycles with no idle cycle between beats.
- R5: cfg_err is 1 when DEPTH is not an integer multiple of the transfer size or the transfer size exceeds DEPTH, and the request stays low while it is 1.
- R6: The request appears only on line dma_req[cfg_req_sel]; all other lines stay low.
- R7: Each accepted beat adds 4 bytes to the total, which saturates at cfg_wc; further beats do not re-raise the request.
- R8: A pulse on cfg_wc_load, or a 0-to-1 change of cfg_en, clears the byte total and re-arms the request.
- R9: With DEPTH words stored, wr_ready is 0 and an offered beat is neither stored nor lost silently.
- R10: After reset the queue is empty (rd_avail 0), wr_ready is 1 and all request lines are low.
- R11: rd_data shows the oldest stored word, a pop with rd_en removes it, and words leave in write order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_en | input | 1 | Enable; a rising change re-arms |
| cfg_thr | input | 3 | Threshold code, transfer size 2^code words |
| cfg_wc | input | WCW | Payload length in bytes |
| cfg_wc_load | input | 1 | Pulse: a new length was written, clears byte total |
| cfg_req_sel | input | 3 | Selects the request output line |
| wr_valid | input | 1 | Write beat offered |
| wr_data | input | 32 | Write beat data |
| wr_ready | output | 1 | Beat accepted when high with wr_valid |
| rd_en | input | 1 | Pop the oldest word |
| rd_data | output | 32 | Oldest stored word |
| rd_avail | output | 1 | Queue holds at least one word |
| dma_req | output | NREQ | Request lines, at most one high |
| cfg_err | output | 1 | Queue size and threshold do not fit |

## Verification
The request rule is tried against pairs of threshold code and fill level placed one word on each side of the boundary. This shows whether the comparison is free-space versus size with the right inclusive edge. Two codes that are illegal for the default depth separate the multiple-of check from the too-large check. A payload length of 37 bytes under an 8-word threshold checks that the request ends on the byte total rather than on chunk boundaries. Bursts to full followed by ordered drains show that back-to-back acceptance, refusal and ordering all hold together.

// File: rtl/txq_dma_req.sv
module txq_dma_req #(
  parameter int DEPTH = 24,
  parameter int NREQ  = 8,
  parameter int WCW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic [2:0]      cfg_thr,
  input  logic [WCW-1:0]  cfg_wc,
  input  logic            cfg_wc_load,
  input  logic [2:0]      cfg_req_sel,
  input  logic            wr_valid,
  input  logic [31:0]     wr_data,
  output logic            wr_ready,
  input  logic            rd_en,
  output logic [31:0]     rd_data,
  output logic            rd_avail,
  output logic [NREQ-1:0] dma_req,
  output logic            cfg_err
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BW = WCW + 1;
  localparam logic [31:0] DEPTH_U = 32'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] level;
  logic [BW-1:0] bytes;
  logic          en_q;

  logic [31:0] thr_w, free_w;
  logic [BW-1:0] wc_x, bytes_inc;
  logic push, pop, done, rearm, req;

  assign push     = wr_valid & wr_ready;
  assign pop      = rd_en & rd_avail;
  assign wr_ready = level != CW'(DEPTH);
  assign rd_avail = level != '0;
  assign rd_data  = mem[rp];

  assign thr_w   = 32'd1 << cfg_thr;
  assign free_w  = DEPTH_U - 32'(level);
  assign cfg_err = (thr_w > DEPTH_U) || ((DEPTH_U & (thr_w - 32'd1)) != 32'd0);

  assign wc_x      = {1'b0, cfg_wc};
  assign bytes_inc = bytes + BW'(4);
  assign done      = bytes >= wc_x;
  assign rearm     = cfg_wc_load | (cfg_en & ~en_q);
  assign req       = cfg_en & ~cfg_err & ~done & (free_w >= thr_w);

  for (genvar i = 0; i < NREQ; i++) begin : g_line
    assign dma_req[i] = req && (cfg_req_sel == 3'(i));
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      bytes <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= cfg_en;
      if (push) wp <= (wp == LAST) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == LAST) ? '0 : rp + PW'(1);
      case ({push, pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
      if (rearm)
        bytes <= '0;
      else if (push && !done)
        bytes <= (bytes_inc >= wc_x) ? wc_x : bytes_inc;
    end
  end
endmodule

// File: rtl/txq_dma_req_chk.sv
module txq_dma_req_chk #(
  parameter int DEPTH = 24,
  parameter int NREQ  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_en,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic            rd_en,
  input logic            rd_avail,
  input logic [NREQ-1:0] dma_req,
  input logic            cfg_err
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + CW'(wr_valid & wr_ready) - CW'(rd_en & rd_avail);
  end

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dma_req)); // R6
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n) (occ == CW'(DEPTH)) |-> !wr_ready); // R9
  AST_ROOM_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n) (occ != CW'(DEPTH)) |-> wr_ready); // R4
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |-> (dma_req == '0)); // R5
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !cfg_en |-> (dma_req == '0)); // R2
  AST_AVAIL_MATCH: assert property (@(posedge clk) disable iff (!rst_n) rd_avail == (occ != '0)); // R11
endmodule

bind txq_dma_req txq_dma_req_chk #(.DEPTH(DEPTH), .NREQ(NREQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_en(rd_en), .rd_avail(rd_avail), .dma_req(dma_req), .cfg_err(cfg_err)
);

// File: tb/tb_txq_dma_req.sv
`timescale 1ns/1ps
module tb_txq_dma_req;
  localparam int DEPTH = 24;
  localparam int NREQ  = 8;
  localparam int WCW   = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_wc_load = 1'b0;
  logic [2:0] cfg_thr = 3'd0, cfg_req_sel = 3'd0;
  logic [WCW-1:0] cfg_wc = '0;
  logic wr_valid = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic wr_ready, rd_avail, cfg_err;
  logic [31:0] rd_data;
  logic [NREQ-1:0] dma_req;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  txq_dma_req #(.DEPTH(DEPTH), .NREQ(NREQ), .WCW(WCW)) dut (.*);

  // threshold code, fill level, expected request (R1, R2, R5)
  localparam int VT [12] = '{0, 0, 0, 3, 3, 2, 2, 1, 1, 4, 5, 3};
  localparam int VF [12] = '{0, 23, 24, 16, 17, 20, 21, 22, 23, 0, 0, 0};
  localparam int VE [12] = '{1, 1, 0, 1, 0, 1, 0, 1, 0, 0, 0, 1};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push_n(input int n, input logic [31:0] base);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = base + 32'(k);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (rd_avail) begin
      rd_en = 1'b1;
      @(negedge clk);
    end
    rd_en = 1'b0;
  endtask

  task automatic load_wc(input logic [WCW-1:0] v);
    @(negedge clk);
    cfg_wc = v;
    cfg_wc_load = 1'b1;
    @(negedge clk);
    cfg_wc_load = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 rd_avail", 32'(rd_avail), 0);
    check("R10 wr_ready", 32'(wr_ready), 1);
    check("R10 dma_req", 32'(dma_req), 0);

    cfg_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      drain();
      cfg_thr     = 3'(VT[i]);
      cfg_req_sel = 3'(i % 8);
      load_wc(16'hFFF0);
      push_n(VF[i], 32'(i * 100));
      #1;
      check($sformatf("R1 R2 R6 vec%0d dma_req", i), 32'(dma_req),
            VE[i] != 0 ? (32'd1 << (i % 8)) : 32'd0);
      check($sformatf("R5 vec%0d cfg_err", i), 32'(cfg_err), VT[i] >= 4 ? 1 : 0);
    end

    // R4 R9 R11: back-to-back burst to full, refused beat, ordered drain
    drain();
    cfg_thr = 3'd0;
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = 32'h1000 + 32'(k * 3);
      #1;
      if (k == 0 || k == DEPTH - 1) check("R4 ready in burst", 32'(wr_ready), 1);
    end
    @(negedge clk);
    wr_data = 32'hDEAD;
    #1;
    check("R9 full refuses", 32'(wr_ready), 0);
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
    check("R9 still full", 32'(wr_ready), 0);
    for (int k = 0; k < DEPTH; k++) begin
      if (k % 6 == 0) check("R11 order", rd_data, 32'h1000 + 32'(k * 3));
      rd_en = 1'b1;
      @(negedge clk);
    end
    rd_en = 1'b0;
    #1;
    check("R9 refused beat not stored", 32'(rd_avail), 0);

    // R3 R7 R8: 37-byte payload with 8-word threshold
    cfg_thr = 3'd3;
    cfg_req_sel = 3'd2;
    load_wc(16'd37);
    #1 check("R8 armed after load", 32'(dma_req), 32'h4);
    push_n(8, 32'h50);
    #1 check("R3 32 bytes", 32'(dma_req), 32'h4);
    push_n(1, 32'h60);
    #1 check("R3 36 bytes", 32'(dma_req), 32'h4);
    push_n(1, 32'h61);
    #1 check("R3 partial last chunk ends request", 32'(dma_req), 0);
    push_n(3, 32'h62);
    #1 check("R7 saturated, stays low", 32'(dma_req), 0);
    load_wc(16'd37);
    #1 check("R8 wc load re-arms", 32'(dma_req), 32'h4);

    drain();
    load_wc(16'd4);
    push_n(1, 32'h70);
    #1 check("R7 one beat completes 4 bytes", 32'(dma_req), 0);
    @(negedge clk);
    cfg_en = 1'b0;
    #1 check("R2 disabled", 32'(dma_req), 0);
    @(negedge clk);
    cfg_en = 1'b1;
    @(negedge clk);
    #1 check("R8 enable rise re-arms", 32'(dma_req), 32'h4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule